// File: doc/BRIEF.md
# Crystal Frequency Auto-Detect with Lock

This block decides which of two supported crystals drives the chip, 16.000 MHz or 5.333 MHz, and presents the answer as a single select bit for the internal clock divider. It runs from an independent, free-running reference clock and treats the crystal oscillator as a sampled data input. A two-flop synchronizer with an edge detector turns each oscillator rising edge into a one-cycle pulse. A meter counts these pulses over a fixed window of reference cycles. At the end of each window the count is compared with a threshold halfway between the counts the two crystals would give.

After power-on the select points at 16 MHz. The first decision arrives when the first window closes, which is about 200 µs at the default parameters. Measurement then repeats window after window until the upstream receiver reports a good telegram. From then on the select and a lock flag are frozen.

A clock watchdog, also running on the reference clock, counts reference cycles since the last oscillator edge. If the oscillator stays silent for the configured limit, the watchdog raises a reset output. That reset also clears the lock and restarts detection from the 16 MHz default. The reset is released as soon as oscillator edges come back.

Top module: `xtal_autodet`

## Requirements
- R1: While and directly after `por_n` is low, `sel_slow` is 0 (0 = 16 MHz, 1 = 5.333 MHz), `locked` is 0 and `wdog_rst` is 0.
- R2: `sel_slow` keeps its 16 MHz default until the first measurement window of `WIN_CYC` reference cycles after reset release has closed.
- R3: At the close of each window, `sel_slow` becomes 1 if fewer than `(FAST_EDGES+SLOW_EDGES)/2` oscillator rising edges were counted in it, and 0 otherwise. The new value is visible from the clock edge that ends the window.
- R4: While unlocked, every window re-evaluates the select, so it can change in either direction. Between window closes it does not change.
- R5: A one-cycle `tlg_ok` pulse while unlocked sets `locked` from the next clock edge.
- R6: While locked, later windows and further `tlg_ok` pulses leave both `sel_slow` and `locked` unchanged.
- R7: If `tlg_ok` falls in the last cycle of a window, that window's result is applied and the lock is taken in the same edge. If `tlg_ok` comes one cycle earlier, the previous select is frozen.
- R8: `wdog_rst` rises once `WDOG_CYC` reference cycles pass without an oscillator rising edge, and not before.
- R9: While `wdog_rst` is high, `locked` and `sel_slow` are held at 0. Only `por_n` or the watchdog clears the lock.
- R10: When oscillator edges return, `wdog_rst` falls within a few cycles and detection restarts unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock; all state runs on it |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| osc_in | input | 1 | Crystal oscillator signal, asynchronous to `clk` |
| tlg_ok | input | 1 | One-cycle pulse: a telegram was received correctly |
| sel_slow | output | 1 | Clock select: 0 = 16 MHz, 1 = 5.333 MHz |
| locked | output | 1 | Select frozen after the first good telegram |
| wdog_rst | output | 1 | Reset request while the oscillator is silent |

## Verification
Two events can land on the same clock edge: a window closing with a new frequency decision, and a telegram pulse that takes the lock. The bench provokes this by releasing reset at a known edge with the slow crystal fitted, then pulsing `tlg_ok` exactly in the window's last cycle. It expects the freshly measured 5.333 MHz select to be frozen together with the lock. A second run moves the pulse one cycle earlier and expects the 16 MHz default to be frozen and to stay frozen past the window close.

// File: rtl/xtal_det_pkg.sv
`timescale 1ns/1ps
package xtal_det_pkg;

    typedef enum logic {
        XSEL_16M  = 1'b0,
        XSEL_5M33 = 1'b1
    } xsel_e;

    typedef struct packed {
        xsel_e sel;
        logic  lock;
    } ctl_state_t;

endpackage

// File: rtl/osc_edge_sync.sv
`timescale 1ns/1ps
module osc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic osc_in,
    output logic rise_p
);
    // bits [STAGES-1:0] synchronize, bit STAGES holds the previous level
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], osc_in};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_p = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter #(
    parameter int WIN_CYC    = 10000,
    parameter int FAST_EDGES = 3200,
    parameter int SLOW_EDGES = 1067
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic edge_p,
    output logic done,
    output logic fast
);
    localparam int CW     = $clog2(WIN_CYC);
    localparam int EW     = $clog2(WIN_CYC + 1);
    localparam int THRESH = (FAST_EDGES + SLOW_EDGES) / 2;

    typedef struct packed {
        logic [CW-1:0] win;
        logic [EW-1:0] cnt;
    } meter_t;

    meter_t m_d, m_q;
    logic          last;
    logic [EW-1:0] sum;

    always_comb begin
        m_d  = m_q;
        last = (m_q.win == CW'(WIN_CYC - 1));
        sum  = m_q.cnt + EW'(edge_p);
        if (clr) begin
            m_d = '0;
        end else if (last) begin
            m_d.win = '0;
            m_d.cnt = '0;
        end else begin
            m_d.win = m_q.win + 1'b1;
            m_d.cnt = sum;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign done = last & ~clr;
    assign fast = (sum >= EW'(THRESH));

    // R3
    window_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
        m_q.win <= CW'(WIN_CYC - 1));

    // R9
    clr_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (m_q.win == '0) && (m_q.cnt == '0));

endmodule

// File: rtl/clk_watchdog.sv
`timescale 1ns/1ps
module clk_watchdog #(
    parameter int WDOG_CYC = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic edge_p,
    output logic trip
);
    localparam int WW = $clog2(WDOG_CYC + 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
        logic          trip;
    } wd_t;

    wd_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (edge_p)
            w_d.cnt = '0;
        else if (w_q.cnt != WW'(WDOG_CYC))
            w_d.cnt = w_q.cnt + 1'b1;
        w_d.trip = (w_d.cnt == WW'(WDOG_CYC));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign trip = w_q.trip;

    // R8
    wdog_no_edge_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(trip) |-> $past(!edge_p));

    // R10
    wdog_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        edge_p |=> !trip);

endmodule

// File: rtl/xtal_autodet.sv
`timescale 1ns/1ps
module xtal_autodet
    import xtal_det_pkg::*;
#(
    parameter int WIN_CYC    = 10000,
    parameter int FAST_EDGES = 3200,
    parameter int SLOW_EDGES = 1067,
    parameter int WDOG_CYC   = 1000,
    parameter int SYNC_STG   = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic osc_in,
    input  logic tlg_ok,
    output logic sel_slow,
    output logic locked,
    output logic wdog_rst
);
    logic osc_rise;
    logic meas_done;
    logic meas_fast;
    logic wd_trip;

    ctl_state_t c_d, c_q;

    osc_edge_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk    (clk),
        .por_n  (por_n),
        .osc_in (osc_in),
        .rise_p (osc_rise)
    );

    freq_meter #(
        .WIN_CYC    (WIN_CYC),
        .FAST_EDGES (FAST_EDGES),
        .SLOW_EDGES (SLOW_EDGES)
    ) i_meter (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (wd_trip),
        .edge_p (osc_rise),
        .done   (meas_done),
        .fast   (meas_fast)
    );

    clk_watchdog #(.WDOG_CYC(WDOG_CYC)) i_wdog (
        .clk    (clk),
        .por_n  (por_n),
        .edge_p (osc_rise),
        .trip   (wd_trip)
    );

    always_comb begin
        c_d = c_q;
        if (wd_trip) begin
            c_d.sel  = XSEL_16M;
            c_d.lock = 1'b0;
        end else if (!c_q.lock) begin
            if (meas_done)
                c_d.sel = meas_fast ? XSEL_16M : XSEL_5M33;
            if (tlg_ok)
                c_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) c_q <= '{sel: XSEL_16M, lock: 1'b0};
        else        c_q <= c_d;
    end

    assign sel_slow = (c_q.sel == XSEL_5M33);
    assign locked   = c_q.lock;
    assign wdog_rst = wd_trip;

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (c_q.lock && !wd_trip) |=> c_q.lock);

    // R6
    frozen_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
        (c_q.lock && !wd_trip) |=> $stable(c_q.sel));

    // R4
    sel_on_done_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!meas_done && !wd_trip) |=> $stable(c_q.sel));

    // R9
    wdog_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        wd_trip |=> (!c_q.lock && c_q.sel == XSEL_16M));

endmodule

// File: tb/test_xtal_autodet.sv
`timescale 1ns/1ps
module test_xtal_autodet;

    localparam int WIN  = 2500;
    localparam int WDOG = 250;
    localparam int M_OFF  = 0;
    localparam int M_FAST = 1;
    localparam int M_SLOW = 2;

    // each entry: crystal for one window (1 = slow) and expected sel_slow after it
    localparam int NV = 6;
    localparam logic [1:0] VEC [NV] = '{
        2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11
    };

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic osc = 1'b0;
    logic tlg_ok = 1'b0;
    logic sel_slow, locked, wdog_rst;
    int   osc_mode = M_FAST;
    int   checks = 0;
    int   fails = 0;

    always #10 clk = ~clk;

    always begin
        case (osc_mode)
            M_FAST:  #31.25 osc = ~osc;
            M_SLOW:  #93.75 osc = ~osc;
            default: #5;
        endcase
    end

    xtal_autodet #(
        .WIN_CYC    (WIN),
        .FAST_EDGES (800),
        .SLOW_EDGES (267),
        .WDOG_CYC   (WDOG)
    ) i_xtal_autodet (
        .clk      (clk),
        .por_n    (por_n),
        .osc_in   (osc),
        .tlg_ok   (tlg_ok),
        .sel_slow (sel_slow),
        .locked   (locked),
        .wdog_rst (wdog_rst)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reset, releasing at a negedge so the first posedge after it is window cycle 1
    task automatic do_por(input int mode);
        osc_mode = mode;
        por_n = 1'b0;
        wait_neg(4);
        chk("R1 sel", sel_slow, 1'b0);
        chk("R1 lock", locked, 1'b0);
        chk("R1 wdog", wdog_rst, 1'b0);
        por_n = 1'b1;
    endtask

    task automatic pulse_tlg;
        tlg_ok = 1'b1;
        wait_neg(1);
        tlg_ok = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        join_none

        wait_neg(2);
        do_por(M_SLOW);

        // R2: default kept up to the last cycle of the first window
        wait_neg(WIN - 1);
        chk("R2 default held", sel_slow, 1'b0);
        wait_neg(1);
        chk("R3 first window slow", sel_slow, VEC[0][0]);

        // R3/R4: table of windows, each crystal set just after a window close
        for (int i = 1; i < NV; i++) begin
            osc_mode = VEC[i][1] ? M_SLOW : M_FAST;
            wait_neg(WIN);
            chk("R4 re-evaluate", sel_slow, VEC[i][0]);
            chk("R4 unlocked", locked, 1'b0);
        end

        // R5: lock on telegram
        pulse_tlg();
        chk("R5 lock set", locked, 1'b1);
        osc_mode = M_FAST;
        wait_neg(2 * WIN);
        chk("R6 sel frozen", sel_slow, 1'b1);
        pulse_tlg();
        chk("R6 second tlg no effect", locked, 1'b1);
        chk("R6 sel still frozen", sel_slow, 1'b1);

        // R8/R9: oscillator stops
        osc_mode = M_OFF;
        wait_neg(WDOG - 10);
        chk("R8 not early", wdog_rst, 1'b0);
        wait_neg(20);
        chk("R8 trips", wdog_rst, 1'b1);
        chk("R9 lock cleared", locked, 1'b0);
        chk("R9 sel default", sel_slow, 1'b0);

        // R10: oscillator returns as slow crystal
        osc_mode = M_SLOW;
        wait_neg(20);
        chk("R10 wdog released", wdog_rst, 1'b0);
        wait_neg(2 * WIN);
        chk("R10 detection restarts", sel_slow, 1'b1);
        chk("R10 unlocked", locked, 1'b0);

        // R7: telegram in the window's last cycle takes that window's result
        do_por(M_SLOW);
        wait_neg(WIN - 1);
        pulse_tlg();
        chk("R7 same-edge sel", sel_slow, 1'b1);
        chk("R7 same-edge lock", locked, 1'b1);

        // R7: telegram one cycle earlier freezes the default
        do_por(M_SLOW);
        wait_neg(WIN - 2);
        pulse_tlg();
        chk("R7 early lock", locked, 1'b1);
        wait_neg(5);
        chk("R7 early sel frozen", sel_slow, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule